// File: doc/BRIEF.md
# Sequenced Multi-Stage Sample Trigger

This block decides when a logic-capture engine should start recording. It watches a stream of wide samples, one per cycle when the valid input is high. It compares each sample against a small set of programmable trigger stages. Each stage holds four words: a care mask, a compare value, an edge-select word and a configuration word.

A bit that is cared for and not edge-selected must simply equal the value bit. A bit that is cared for and edge-selected must also have changed since the previous sample, in the direction named by its value bit. The configuration word gives each stage an arming level and a start flag.

A shared level counter steps the stages through a sequence. A stage only competes once the counter has reached its level. A matching stage without the start flag advances the counter. A matching stage with the start flag fires a one-clock trigger pulse. Only one pulse is produced per run.

Software programs the stages through a simple write port. It pulses the run-start input before each capture. For an immediate capture, it gives stage 0 a zero mask, level 0 and the start flag. An unused stage is parked with all-zero words and level 3.

Top module: `trg_seq_unit`

## Requirements
- R1: After reset, trig_out is low, the level counter is 0 and every stage register is zero, so no trigger fires until a start flag is programmed.
- R2: When cfg_we is high at a clock edge, the register of stage cfg_stage named by cfg_sel is loaded from cfg_wdata. The cfg_sel encoding is 0 = mask, 1 = value, 2 = configuration, 3 = edge select.
- R3: A bit whose mask bit is 1 and whose edge bit is 0 matches only when the sample bit equals the value bit. A bit whose mask bit is 0 never affects the match.
- R4: A bit whose mask and edge bits are both 1 is an edge condition. With value bit 1 it needs previous sample 0 and current sample 1 (rising). With value bit 0 it needs previous 1 and current 0 (falling).
- R5: A stage with any edge condition cannot match on the first valid sample after reset or run_start, since no previous sample exists yet.
- R6: A stage takes part only while the level counter is greater than or equal to its configuration bits 23:16.
- R7: When at least one participating stage without the start flag (configuration bit 27) matches a valid sample, and no start stage matches it, the level counter rises by one. The counter saturates at 255 and never decreases except on run_start.
- R8: A match of a participating stage with the start flag raises trig_out for exactly one clock, in the cycle after the edge that took the sample.
- R9: At most one trigger pulse is produced per run. Later start matches are ignored until run_start.
- R10: run_start clears the level counter, the previous-sample history and the fired state. It takes priority over a valid sample in the same cycle, which is then discarded.
- R11: A sample offered with smp_valid low changes neither the level counter, nor the previous sample, nor trig_out.
- R12: A stage whose mask, value and edge words are all zero matches every valid sample once its level is reached. With level 0 and the start flag, this fires on the first sample of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Pulse before each capture; clears sequence state |
| cfg_we | input | 1 | Stage register write enable |
| cfg_stage | input | $clog2(NUM_STAGES) | Stage index for the write |
| cfg_sel | input | 2 | Register select: 0 mask, 1 value, 2 config, 3 edge |
| cfg_wdata | input | SMP_W | Write data |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | SMP_W | Sample word |
| trig_out | output | 1 | One-clock trigger pulse |

## Verification
A wrong level counter shows up as a trigger that appears one or more samples too early, or never appears. A wrong counter that drops back would, for example, hide a start stage parked at a high level. A lost or stale previous-sample word shows at trig_out within one valid sample, as an edge stage firing on a non-transition or missing a real one. A stuck fired state shows as a second pulse in the same run, or a missing pulse after run_start. Every such fault is visible at trig_out one clock after the sample that exposes it.

// File: rtl/trg_pkg.sv
package trg_pkg;

    // Configuration word field positions (software-visible layout)
    localparam int CFG_LVL_LSB   = 16;
    localparam int CFG_LVL_W     = 8;
    localparam int CFG_START_BIT = 27;
    localparam int CFG_MIN_W     = CFG_START_BIT + 1;

    localparam logic [CFG_LVL_W-1:0] LVL_MAX = {CFG_LVL_W{1'b1}};

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_VALUE  = 2'd1,
        REG_CONFIG = 2'd2,
        REG_EDGE   = 2'd3
    } trg_reg_e;

    typedef struct packed {
        logic                 start;
        logic [CFG_LVL_W-1:0] lvl;
    } stage_cfg_t;

    typedef struct packed {
        logic hit;
        logic start;
    } stage_res_t;

    function automatic logic [CFG_LVL_W-1:0] lvl_step(input logic [CFG_LVL_W-1:0] cur);
        return (cur == LVL_MAX) ? cur : cur + 1'b1;
    endfunction

endpackage

// File: rtl/trg_stage.sv
module trg_stage
    import trg_pkg::*;
#(
    parameter int SMP_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  trg_reg_e             sel,
    input  logic [SMP_W-1:0]     wdata,
    input  logic [SMP_W-1:0]     smp,
    input  logic [SMP_W-1:0]     prev,
    input  logic                 prev_vld,
    input  logic [CFG_LVL_W-1:0] cur_lvl,
    output stage_res_t           res
);

    logic [SMP_W-1:0] mask_q, value_q, edge_q;
    stage_cfg_t       cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            value_q <= '0;
            edge_q  <= '0;
            cfg_q   <= '0;
        end else if (we) begin
            unique case (sel)
                REG_MASK:   mask_q  <= wdata;
                REG_VALUE:  value_q <= wdata;
                REG_EDGE:   edge_q  <= wdata;
                REG_CONFIG: begin
                    cfg_q.lvl   <= wdata[CFG_LVL_LSB +: CFG_LVL_W];
                    cfg_q.start <= wdata[CFG_START_BIT];
                end
                default: ;
            endcase
        end
    end

    logic [SMP_W-1:0] edge_care;
    logic             armed, lvl_ok, edge_ok;

    always_comb begin
        edge_care = mask_q & edge_q;
        armed     = (cur_lvl >= cfg_q.lvl);
        lvl_ok    = ~|((smp ^ value_q) & mask_q);
        // previous bit must be the opposite of the wanted final state
        edge_ok   = (edge_care == '0) ||
                    (prev_vld && (((prev ^ value_q) & edge_care) == edge_care));
        res.hit   = armed && lvl_ok && edge_ok;
        res.start = cfg_q.start;
    end

endmodule

// File: rtl/trg_sequencer.sv
module trg_sequencer
    import trg_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int SMP_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_start,
    input  logic                  smp_valid,
    input  logic [SMP_W-1:0]      smp_data,
    input  logic [NUM_STAGES-1:0] hit_vec,
    input  logic [NUM_STAGES-1:0] start_vec,
    output logic [SMP_W-1:0]      prev,
    output logic                  prev_vld,
    output logic [CFG_LVL_W-1:0]  cur_lvl,
    output logic                  trig_out
);

    logic fired;
    logic any_start, any_step;

    always_comb begin
        any_start = |(hit_vec & start_vec);
        any_step  = |(hit_vec & ~start_vec);
    end

    always_ff @(posedge clk) begin
        if (rst || run_start) begin
            prev     <= '0;
            prev_vld <= 1'b0;
            cur_lvl  <= '0;
            fired    <= 1'b0;
            trig_out <= 1'b0;
        end else begin
            trig_out <= 1'b0;
            if (smp_valid) begin
                prev     <= smp_data;
                prev_vld <= 1'b1;
                if (any_start) begin
                    if (!fired) begin
                        trig_out <= 1'b1;
                        fired    <= 1'b1;
                    end
                end else if (any_step) begin
                    cur_lvl <= lvl_step(cur_lvl);
                end
            end
        end
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    // R11
    trig_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> $past(smp_valid));

    // R11
    idle_lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !run_start) |=> $stable(cur_lvl));

    // R10
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        run_start |=> (cur_lvl == '0 && !trig_out && !prev_vld));

    // R7
    lvl_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !run_start |=> cur_lvl >= $past(cur_lvl));

endmodule

// File: rtl/trg_seq_unit.sv
module trg_seq_unit
    import trg_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int SMP_W      = 32,
    localparam int IDX_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_start,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_stage,
    input  logic [1:0]       cfg_sel,
    input  logic [SMP_W-1:0] cfg_wdata,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             trig_out
);

    logic [SMP_W-1:0]      prev;
    logic                  prev_vld;
    logic [CFG_LVL_W-1:0]  cur_lvl;
    logic [NUM_STAGES-1:0] hit_vec, start_vec;
    trg_reg_e              sel_e;

    assign sel_e = trg_reg_e'(cfg_sel);

    initial begin
        if (SMP_W < CFG_MIN_W) $display("trg_seq_unit: SMP_W too small for config fields");
    end

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        stage_res_t res;
        logic       we_i;

        assign we_i = cfg_we && (cfg_stage == IDX_W'(i));

        trg_stage #(.SMP_W(SMP_W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .we       (we_i),
            .sel      (sel_e),
            .wdata    (cfg_wdata),
            .smp      (smp_data),
            .prev     (prev),
            .prev_vld (prev_vld),
            .cur_lvl  (cur_lvl),
            .res      (res)
        );

        assign hit_vec[i]   = res.hit;
        assign start_vec[i] = res.start;
    end

    trg_sequencer #(.NUM_STAGES(NUM_STAGES), .SMP_W(SMP_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run_start (run_start),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .hit_vec   (hit_vec),
        .start_vec (start_vec),
        .prev      (prev),
        .prev_vld  (prev_vld),
        .cur_lvl   (cur_lvl),
        .trig_out  (trig_out)
    );

endmodule

// File: tb/trg_seq_unit_tb.sv
module trg_seq_unit_tb;

    localparam int NS = 4;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_start = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_stage = '0;
    logic [1:0]    cfg_sel = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic          smp_valid = 1'b0;
    logic [W-1:0]  smp_data = '0;
    logic          trig_out;

    always #2.5 clk = ~clk;

    trg_seq_unit #(.NUM_STAGES(NS), .SMP_W(W)) u_dut (
        .clk(clk), .rst(rst), .run_start(run_start), .cfg_we(cfg_we),
        .cfg_stage(cfg_stage), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .trig_out(trig_out)
    );

    // reference model state
    logic [W-1:0] m_mask [NS];
    logic [W-1:0] m_val  [NS];
    logic [W-1:0] m_edge [NS];
    logic [7:0]   m_lvlc [NS];
    bit           m_strt [NS];
    int           m_lvl;
    logic [W-1:0] m_prev;
    bit           m_pv, m_fired;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: trig_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit stage_ok(input int i, input logic [W-1:0] d);
        logic [W-1:0] want_edge;
        want_edge = m_mask[i] & m_edge[i];
        if (m_lvl < int'(m_lvlc[i])) return 0;
        for (int b = 0; b < W; b++) begin
            if (m_mask[i][b] && d[b] != m_val[i][b]) return 0;
            if (want_edge[b] && (!m_pv || m_prev[b] == m_val[i][b])) return 0;
        end
        return 1;
    endfunction

    task automatic model_clear();
        m_lvl = 0; m_prev = '0; m_pv = 0; m_fired = 0;
    endtask

    task automatic wr(input int st, input int sel, input logic [W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stage = 2'(st); cfg_sel = 2'(sel); cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        case (sel)
            0: m_mask[st] = d;
            1: m_val[st]  = d;
            2: begin m_lvlc[st] = d[23:16]; m_strt[st] = d[27]; end
            default: m_edge[st] = d;
        endcase
    endtask

    task automatic prog(input int st, input logic [W-1:0] mk, input logic [W-1:0] vl,
                        input logic [W-1:0] ed, input int lvl, input bit strt);
        wr(st, 0, mk);
        wr(st, 1, vl);
        wr(st, 3, ed);
        wr(st, 2, (W'(lvl & 255) << 16) | (W'(strt) << 27));
    endtask

    task automatic park_all();
        for (int i = 0; i < NS; i++) prog(i, '0, '0, '0, 3, 0);
    endtask

    // one cycle: optional run_start, optional sample; checks trig_out after the edge
    task automatic step(input bit rs, input bit vld, input logic [W-1:0] d, input string tag);
        bit exp, s_hit, n_hit;
        @(negedge clk);
        run_start = rs; smp_valid = vld; smp_data = d;
        exp = 0;
        if (rs) begin
            model_clear();
        end else if (vld) begin
            s_hit = 0; n_hit = 0;
            for (int i = 0; i < NS; i++) begin
                if (stage_ok(i, d)) begin
                    if (m_strt[i]) s_hit = 1; else n_hit = 1;
                end
            end
            if (s_hit) begin
                if (!m_fired) begin exp = 1; m_fired = 1; end
            end else if (n_hit && m_lvl < 255) begin
                m_lvl++;
            end
            m_prev = d; m_pv = 1;
        end
        @(posedge clk);
        #1;
        run_start = 1'b0; smp_valid = 1'b0;
        check(tag, trig_out, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NS; i++) begin
            m_mask[i] = '0; m_val[i] = '0; m_edge[i] = '0; m_lvlc[i] = '0; m_strt[i] = 0;
        end
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 reset", trig_out, 1'b0);

        // R1 / R12: zero registers match but nothing carries the start flag
        for (int k = 0; k < 4; k++) step(0, 1, W'($urandom), "R1 no start after reset");

        // R12: forced immediate trigger; R2 writes land in the right stage/register
        park_all();
        prog(0, '0, '0, '0, 0, 1);
        step(1, 0, '0, "R10 run_start");
        step(0, 1, 32'hdead_beef, "R12 immediate fire");
        // R9: one shot per run
        step(0, 1, 32'h0, "R9 no second pulse");
        step(0, 1, 32'h1, "R9 no second pulse");
        // R10: re-arm
        step(1, 0, '0, "R10 rearm");
        step(0, 0, 32'h0, "R11 invalid sample ignored");
        step(0, 1, 32'h0, "R8 pulse after rearm");

        // R3 / R6 / R7: two-step sequence
        park_all();
        prog(0, 32'h0000_00ff, 32'h0000_00a5, '0, 0, 0);
        prog(1, 32'h0000_ff00, 32'h0000_3c00, '0, 1, 1);
        step(1, 0, '0, "R10");
        step(0, 1, 32'h0000_3c00, "R6 stage1 not yet armed");
        step(0, 1, 32'hffff_ffa4, "R3 mismatch bit0");
        step(0, 0, 32'h0000_00a5, "R11 invalid no level step");
        step(0, 1, 32'h0000_3c00, "R11 level unchanged");
        step(0, 1, 32'h1234_00a5, "R3 masked-out bits ignored, R7 step");
        step(0, 1, 32'h0000_3c11, "R8 start fires at level 1");

        // R4 / R5 rising edge on bit 4
        park_all();
        prog(0, 32'h10, 32'h10, 32'h10, 0, 1);
        step(1, 0, '0, "R10");
        step(0, 1, 32'h10, "R5 no edge on first sample");
        step(0, 1, 32'h10, "R4 high-high not rising");
        step(0, 1, 32'h00, "R4 falling not rising");
        step(0, 1, 32'h10, "R4 rising fires");

        // R4 falling edge on bit 31
        park_all();
        prog(2, 32'h8000_0000, 32'h0, 32'h8000_0000, 0, 1);
        step(1, 0, '0, "R10");
        step(0, 1, 32'h8000_0000, "R5 first sample");
        step(0, 1, 32'h0, "R4 falling fires");

        // R10: run_start beats a same-cycle sample
        park_all();
        prog(0, '0, '0, '0, 0, 1);
        step(1, 1, 32'h0, "R10 sample discarded with run_start");
        step(0, 1, 32'h0, "R10 fires on next sample");

        // R7 saturation: stage1 parked at level 255 waiting on bit 31
        park_all();
        prog(0, '0, '0, '0, 0, 0);
        prog(1, 32'h8000_0000, 32'h8000_0000, '0, 255, 1);
        step(1, 0, '0, "R10");
        for (int k = 0; k < 300; k++) step(0, 1, 32'h8000_0000 & 32'(k & 0), "R7 counting");
        step(0, 1, 32'h8000_0000, "R7 saturated level fires");

        // constrained random
        park_all();
        step(1, 0, '0, "R10");
        for (int k = 0; k < 2000; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 4) begin
                logic [W-1:0] mk;
                mk = W'($urandom) & 32'hf;
                prog(int'($urandom % NS), mk, W'($urandom) & 32'hf,
                     mk & W'($urandom), int'($urandom % 3), ($urandom % 4) == 0);
            end else if (r < 7) begin
                step(1, $urandom % 2 == 0, W'($urandom) & 32'hf, "R10 random run");
            end else begin
                step(0, ($urandom % 4) != 0, W'($urandom) & 32'hf, "R8 random");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule